// File: doc/BRIEF.md
# USB Endpoint Buffer Segment Mapper

This block sits between a USB device's packet engine and one shared 512-byte packet SRAM. It holds six endpoint slots. For each slot, software sets a window start inside the SRAM, a payload cap, a transfer kind and an endpoint number. Software writes these over a small register bus. A separate register holds the device's function address.

When the packet engine presents a token, the block picks the endpoint slot that the token belongs to. It then turns the byte requests that follow into a stream of SRAM addresses inside that slot's window, and it stops accepting bytes at the payload cap. Bytes received on receive-type slots are written into the window and counted per slot. Transmit-type slots read their bytes out of the window.

A CPU-side port reads and writes the same SRAM. It yields to the packet engine when both want the memory in the same cycle.

Top module: `usb_ep_bufmap`

## Requirements
- R1: After reset, every slot field reads 0: kind off, start 0, cap 0, endpoint 0, count 0. The device address reads 0. `tok_hit`, `tok_miss` and `eng_ack` are low.
- R2: Configuration uses `cfg_addr[5:3]` as the slot and `cfg_addr[2:0]` as the field. Field 0 is the start offset (9 bits), 1 is the payload cap, 2 is the kind, 3 is the endpoint number (4 bits) and 4 is the received count. Slot value 6 with field 0 is the 7-bit device address. A write takes effect at the clock edge, and `cfg_rdata` shows the addressed field combinationally. A cap written above 512 is stored as 512. Writes to the count field are ignored.
- R3: A token with kind code 1 (IN), 2 (OUT) or 3 (SETUP) hits a slot only when three things hold: the token address equals the device address, the token endpoint equals the slot's endpoint, and the token kind equals the slot's kind. A slot of kind 0 never hits. `tok_hit` and `tok_slot` are valid in the cycle after `tok_valid`.
- R4: When several slots hit, the lowest-numbered slot is chosen.
- R5: A token that hits no slot raises `tok_miss` for one cycle and closes any open transfer. No SRAM access is then granted to the engine (`eng_ack` stays low).
- R6: During a transfer, `eng_addr` equals (slot start + byte index) mod 512. The index is 0 after the hit and advances by one per acknowledged byte.
- R7: `eng_ack` is low and `eng_full` is high once the index equals the slot's payload cap. A cap of 0 accepts no byte.
- R8: On OUT and SETUP slots, each acknowledged byte writes `eng_wdata` to the SRAM. The slot's count field holds the number of bytes accepted since the hit and is cleared to 0 by the hit.
- R9: On IN slots, `eng_rdata` holds the SRAM byte at the acknowledged address in the cycle after the acknowledge.
- R10: `cpu_gnt` is high when `cpu_req` is high and the engine is not acknowledged in that cycle. A granted write lands at that edge. A granted read shows on `cpu_rdata` in the next cycle, and `cpu_rdata` holds otherwise.
- R11: In a cycle with `tok_valid` high, `eng_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 6 | Slot (bits 5:3) and field (bits 2:0) |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data, combinational |
| tok_valid | input | 1 | Token present this cycle |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 4 | Token endpoint number |
| tok_kind | input | 2 | Token kind: 1 IN, 2 OUT, 3 SETUP |
| tok_hit | output | 1 | Token matched a slot (one-cycle pulse) |
| tok_miss | output | 1 | Token matched no slot (one-cycle pulse) |
| tok_slot | output | 3 | Slot of the current transfer |
| eng_req | input | 1 | Engine byte request |
| eng_wdata | input | 8 | Byte from engine (OUT/SETUP) |
| eng_ack | output | 1 | Engine byte accepted this cycle |
| eng_full | output | 1 | Index has reached the payload cap |
| eng_addr | output | 9 | SRAM address of the current byte |
| eng_rdata | output | 8 | Byte read for IN, one cycle after acknowledge |
| cpu_req | input | 1 | CPU SRAM request |
| cpu_wr | input | 1 | CPU write when 1 |
| cpu_addr | input | 9 | CPU SRAM address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_gnt | output | 1 | CPU request served this cycle |
| cpu_rdata | output | 8 | CPU read data |

## Verification
The assertions on the byte index assume two things: the payload cap and kind of the slot in an open transfer are not rewritten while it is open, and the slot number behind `tok_slot` comes only from a hit. The bench keeps to this by closing any open transfer with a kind-0 token before every configuration write. A kind-0 token can never hit. The read-data hold property assumes `cpu_wr` is steady while a request is granted; the bench drives each CPU access for exactly one cycle. Random tokens mix wrong addresses, unconfigured kinds and duplicate endpoint numbers, so both the hit path and the miss path are exercised under those limits.

// File: rtl/usb_ep_bufmap_pkg.sv
package usb_ep_bufmap_pkg;
    typedef enum logic [1:0] {
        EPK_OFF   = 2'd0,
        EPK_IN    = 2'd1,
        EPK_OUT   = 2'd2,
        EPK_SETUP = 2'd3
    } ep_kind_e;

    localparam int DEV_W = 7;
    localparam int EPN_W = 4;
    localparam int CFG_DW = 16;

    localparam logic [2:0] FLD_START = 3'd0;
    localparam logic [2:0] FLD_MAXP  = 3'd1;
    localparam logic [2:0] FLD_KIND  = 3'd2;
    localparam logic [2:0] FLD_EPNUM = 3'd3;
    localparam logic [2:0] FLD_COUNT = 3'd4;
endpackage

// File: rtl/ep_cfg_regs.sv
module ep_cfg_regs
    import usb_ep_bufmap_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int BUF_BYTES = 512,
    parameter int AW = 9,
    parameter int LW = 10,
    parameter int SLOT_W = 3,
    localparam int CFG_AW = SLOT_W + 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_sel_i,
    input  logic                         cfg_write_i,
    input  logic [CFG_AW-1:0]            cfg_addr_i,
    input  logic [CFG_DW-1:0]            cfg_wdata_i,
    output logic [CFG_DW-1:0]            cfg_rdata_o,
    input  logic                         cnt_we_i,
    input  logic [SLOT_W-1:0]            cnt_slot_i,
    input  logic [LW-1:0]                cnt_val_i,
    output logic [NSLOT-1:0][AW-1:0]     start_o,
    output logic [NSLOT-1:0][LW-1:0]     maxp_o,
    output logic [NSLOT-1:0][1:0]        kind_o,
    output logic [NSLOT-1:0][EPN_W-1:0]  epn_o,
    output logic [DEV_W-1:0]             dev_o
);
    localparam logic [CFG_DW-1:0] CAP = CFG_DW'(BUF_BYTES);

    typedef struct packed {
        logic [NSLOT-1:0][AW-1:0]    start;
        logic [NSLOT-1:0][LW-1:0]    maxp;
        logic [NSLOT-1:0][1:0]       kind;
        logic [NSLOT-1:0][EPN_W-1:0] epn;
        logic [NSLOT-1:0][LW-1:0]    cnt;
        logic [DEV_W-1:0]            dev;
    } cfg_s;

    cfg_s s_d, s_q;
    logic [SLOT_W-1:0] sel_slot;
    logic [2:0]        sel_fld;

    assign sel_slot = cfg_addr_i[CFG_AW-1:3];
    assign sel_fld  = cfg_addr_i[2:0];

    always_comb begin
        s_d = s_q;
        if (cfg_sel_i && cfg_write_i) begin
            if (int'(sel_slot) < NSLOT) begin
                case (sel_fld)
                    FLD_START: s_d.start[sel_slot] = cfg_wdata_i[AW-1:0];
                    FLD_MAXP:  s_d.maxp[sel_slot]  = (cfg_wdata_i > CAP) ? LW'(BUF_BYTES)
                                                                         : cfg_wdata_i[LW-1:0];
                    FLD_KIND:  s_d.kind[sel_slot]  = cfg_wdata_i[1:0];
                    FLD_EPNUM: s_d.epn[sel_slot]   = cfg_wdata_i[EPN_W-1:0];
                    default:   ;
                endcase
            end else if (int'(sel_slot) == NSLOT && sel_fld == FLD_START) begin
                s_d.dev = cfg_wdata_i[DEV_W-1:0];
            end
        end
        if (cnt_we_i) begin
            s_d.cnt[cnt_slot_i] = cnt_val_i;
        end
    end

    always_comb begin
        cfg_rdata_o = '0;
        if (int'(sel_slot) < NSLOT) begin
            case (sel_fld)
                FLD_START: cfg_rdata_o = CFG_DW'(s_q.start[sel_slot]);
                FLD_MAXP:  cfg_rdata_o = CFG_DW'(s_q.maxp[sel_slot]);
                FLD_KIND:  cfg_rdata_o = CFG_DW'(s_q.kind[sel_slot]);
                FLD_EPNUM: cfg_rdata_o = CFG_DW'(s_q.epn[sel_slot]);
                FLD_COUNT: cfg_rdata_o = CFG_DW'(s_q.cnt[sel_slot]);
                default:   cfg_rdata_o = '0;
            endcase
        end else if (int'(sel_slot) == NSLOT && sel_fld == FLD_START) begin
            cfg_rdata_o = CFG_DW'(s_q.dev);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_o = s_q.start;
    assign maxp_o  = s_q.maxp;
    assign kind_o  = s_q.kind;
    assign epn_o   = s_q.epn;
    assign dev_o   = s_q.dev;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cap_chk
        AST_MAXP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.maxp[g] <= LW'(BUF_BYTES)); // R2
    end
endmodule

// File: rtl/ep_match.sv
module ep_match
    import usb_ep_bufmap_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int SLOT_W = 3
) (
    input  logic [NSLOT-1:0][1:0]       kind_i,
    input  logic [NSLOT-1:0][EPN_W-1:0] epn_i,
    input  logic [DEV_W-1:0]            dev_i,
    input  logic [DEV_W-1:0]            tok_addr_i,
    input  logic [EPN_W-1:0]            tok_ep_i,
    input  logic [1:0]                  tok_kind_i,
    output logic                        found_o,
    output logic [SLOT_W-1:0]           slot_o
);
    logic [NSLOT-1:0] mvec;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign mvec[g] = (kind_i[g] != EPK_OFF) && (kind_i[g] == tok_kind_i)
                      && (epn_i[g] == tok_ep_i) && (tok_addr_i == dev_i);
    end

    always_comb begin
        found_o = 1'b0;
        slot_o  = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (mvec[i]) begin
                found_o = 1'b1;
                slot_o  = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/ep_xfer.sv
module ep_xfer
    import usb_ep_bufmap_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int AW = 9,
    parameter int LW = 10,
    parameter int SLOT_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tok_valid_i,
    input  logic                     found_i,
    input  logic [SLOT_W-1:0]        slot_i,
    input  logic [NSLOT-1:0][AW-1:0] start_i,
    input  logic [NSLOT-1:0][LW-1:0] maxp_i,
    input  logic [NSLOT-1:0][1:0]    kind_i,
    input  logic                     eng_req_i,
    output logic                     hit_o,
    output logic                     miss_o,
    output logic [SLOT_W-1:0]        slot_o,
    output logic                     eng_ack_o,
    output logic                     eng_full_o,
    output logic                     eng_wr_o,
    output logic [AW-1:0]            eng_addr_o,
    output logic                     cnt_we_o,
    output logic [SLOT_W-1:0]        cnt_slot_o,
    output logic [LW-1:0]            cnt_val_o
);
    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slot;
        logic [LW-1:0]     idx;
        logic              hit;
        logic              miss;
    } xfer_s;

    xfer_s s_d, s_q;
    logic [AW-1:0] cur_start;
    logic [LW-1:0] cur_maxp;
    logic [1:0]    cur_kind;

    always_comb begin
        cur_start  = start_i[s_q.slot];
        cur_maxp   = maxp_i[s_q.slot];
        cur_kind   = kind_i[s_q.slot];
        eng_full_o = s_q.active && (s_q.idx >= cur_maxp);
        eng_ack_o  = s_q.active && !eng_full_o && eng_req_i && !tok_valid_i;
        eng_addr_o = cur_start + s_q.idx[AW-1:0];
        eng_wr_o   = (cur_kind != EPK_IN);

        s_d        = s_q;
        s_d.hit    = 1'b0;
        s_d.miss   = 1'b0;
        cnt_we_o   = 1'b0;
        cnt_slot_o = s_q.slot;
        cnt_val_o  = s_q.idx + LW'(1);

        if (tok_valid_i) begin
            s_d.active = found_i;
            s_d.idx    = '0;
            s_d.hit    = found_i;
            s_d.miss   = !found_i;
            if (found_i) begin
                s_d.slot = slot_i;
                if (kind_i[slot_i] != EPK_IN) begin
                    cnt_we_o   = 1'b1;
                    cnt_slot_o = slot_i;
                    cnt_val_o  = '0;
                end
            end
        end else if (eng_ack_o) begin
            s_d.idx  = s_q.idx + LW'(1);
            cnt_we_o = eng_wr_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_o  = s_q.hit;
    assign miss_o = s_q.miss;
    assign slot_o = s_q.slot;

    AST_HIT_AFTER_TOK: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hit |-> $past(tok_valid_i)); // R3
    AST_MISS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.miss |-> !eng_ack_o); // R5
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ack_o |=> s_q.idx == $past(s_q.idx) + LW'(1)); // R6
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> s_q.idx <= cur_maxp); // R7
endmodule

// File: rtl/buf_sram.sv
module buf_sram #(
    parameter int DEPTH = 512,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_acc_i,
    input  logic          eng_wr_i,
    input  logic [AW-1:0] eng_addr_i,
    input  logic [7:0]    eng_wdata_i,
    output logic [7:0]    eng_rdata_o,
    input  logic          cpu_req_i,
    input  logic          cpu_wr_i,
    input  logic [AW-1:0] cpu_addr_i,
    input  logic [7:0]    cpu_wdata_i,
    output logic          cpu_gnt_o,
    output logic [7:0]    cpu_rdata_o
);
    typedef struct packed {
        logic [7:0] eng_rd;
        logic [7:0] cpu_rd;
    } rd_s;

    logic [7:0]    mem [DEPTH];
    rd_s           s_d, s_q;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    always_comb begin
        cpu_gnt_o = cpu_req_i && !eng_acc_i;
        s_d       = s_q;
        wr_en     = 1'b0;
        wr_addr   = eng_addr_i;
        wr_data   = eng_wdata_i;
        if (eng_acc_i) begin
            if (eng_wr_i) wr_en = 1'b1;
            else          s_d.eng_rd = mem[eng_addr_i];
        end else if (cpu_gnt_o) begin
            if (cpu_wr_i) begin
                wr_en   = 1'b1;
                wr_addr = cpu_addr_i;
                wr_data = cpu_wdata_i;
            end else begin
                s_d.cpu_rd = mem[cpu_addr_i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign eng_rdata_o = s_q.eng_rd;
    assign cpu_rdata_o = s_q.cpu_rd;

    AST_CPU_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_gnt_o && !cpu_wr_i) |=> $stable(cpu_rdata_o)); // R10
endmodule

// File: rtl/usb_ep_bufmap.sv
module usb_ep_bufmap
    import usb_ep_bufmap_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int BUF_BYTES = 512,
    localparam int AW = $clog2(BUF_BYTES),
    localparam int LW = AW + 1,
    localparam int SLOT_W = $clog2(NSLOT + 1),
    localparam int CFG_AW = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              tok_valid,
    input  logic [DEV_W-1:0]  tok_addr,
    input  logic [EPN_W-1:0]  tok_ep,
    input  logic [1:0]        tok_kind,
    output logic              tok_hit,
    output logic              tok_miss,
    output logic [SLOT_W-1:0] tok_slot,
    input  logic              eng_req,
    input  logic [7:0]        eng_wdata,
    output logic              eng_ack,
    output logic              eng_full,
    output logic [AW-1:0]     eng_addr,
    output logic [7:0]        eng_rdata,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_gnt,
    output logic [7:0]        cpu_rdata
);
    logic [NSLOT-1:0][AW-1:0]    start;
    logic [NSLOT-1:0][LW-1:0]    maxp;
    logic [NSLOT-1:0][1:0]       kind;
    logic [NSLOT-1:0][EPN_W-1:0] epn;
    logic [DEV_W-1:0]            dev;
    logic                        found;
    logic [SLOT_W-1:0]           mslot;
    logic                        cnt_we;
    logic [SLOT_W-1:0]           cnt_slot;
    logic [LW-1:0]               cnt_val;
    logic                        eng_wr;

    ep_cfg_regs #(.NSLOT(NSLOT), .BUF_BYTES(BUF_BYTES), .AW(AW), .LW(LW), .SLOT_W(SLOT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_sel_i(cfg_sel), .cfg_write_i(cfg_write), .cfg_addr_i(cfg_addr),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
        .cnt_we_i(cnt_we), .cnt_slot_i(cnt_slot), .cnt_val_i(cnt_val),
        .start_o(start), .maxp_o(maxp), .kind_o(kind), .epn_o(epn), .dev_o(dev)
    );

    ep_match #(.NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_match (
        .kind_i(kind), .epn_i(epn), .dev_i(dev),
        .tok_addr_i(tok_addr), .tok_ep_i(tok_ep), .tok_kind_i(tok_kind),
        .found_o(found), .slot_o(mslot)
    );

    ep_xfer #(.NSLOT(NSLOT), .AW(AW), .LW(LW), .SLOT_W(SLOT_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .tok_valid_i(tok_valid), .found_i(found), .slot_i(mslot),
        .start_i(start), .maxp_i(maxp), .kind_i(kind), .eng_req_i(eng_req),
        .hit_o(tok_hit), .miss_o(tok_miss), .slot_o(tok_slot),
        .eng_ack_o(eng_ack), .eng_full_o(eng_full), .eng_wr_o(eng_wr), .eng_addr_o(eng_addr),
        .cnt_we_o(cnt_we), .cnt_slot_o(cnt_slot), .cnt_val_o(cnt_val)
    );

    buf_sram #(.DEPTH(BUF_BYTES), .AW(AW)) u_sram (
        .clk(clk), .rst_n(rst_n),
        .eng_acc_i(eng_ack), .eng_wr_i(eng_wr), .eng_addr_i(eng_addr),
        .eng_wdata_i(eng_wdata), .eng_rdata_o(eng_rdata),
        .cpu_req_i(cpu_req), .cpu_wr_i(cpu_wr), .cpu_addr_i(cpu_addr),
        .cpu_wdata_i(cpu_wdata), .cpu_gnt_o(cpu_gnt), .cpu_rdata_o(cpu_rdata)
    );
endmodule

// File: tb/usb_ep_bufmap_bench.sv
module usb_ep_bufmap_bench;
    localparam int NS = 6;
    localparam int BUF = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        cfg_sel = 0, cfg_write = 0;
    logic [5:0]  cfg_addr = 0;
    logic [15:0] cfg_wdata = 0, cfg_rdata;
    logic        tok_valid = 0;
    logic [6:0]  tok_addr = 0;
    logic [3:0]  tok_ep = 0;
    logic [1:0]  tok_kind = 0;
    logic        tok_hit, tok_miss;
    logic [2:0]  tok_slot;
    logic        eng_req = 0;
    logic [7:0]  eng_wdata = 0;
    logic        eng_ack, eng_full;
    logic [8:0]  eng_addr;
    logic [7:0]  eng_rdata;
    logic        cpu_req = 0, cpu_wr = 0;
    logic [8:0]  cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0;
    logic        cpu_gnt;
    logic [7:0]  cpu_rdata;

    usb_ep_bufmap u_usb_ep_bufmap (.*);

    int checks = 0, fails = 0;
    int m_start[NS], m_maxp[NS], m_kind[NS], m_ep[NS], m_cnt[NS];
    int m_dev = 0;
    logic [7:0] m_mem [BUF];
    int act = 0, aslot = 0, aidx = 0;

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic int exp_match(input int a, input int e, input int k);
        for (int i = 0; i < NS; i++)
            if (m_kind[i] != 0 && m_kind[i] == k && m_ep[i] == e && a == m_dev) return i;
        return -1;
    endfunction

    task automatic token(input int a, input int e, input int k, input bit with_req, input bit check);
        int x = exp_match(a, e, k);
        @(negedge clk);
        tok_valid = 1; tok_addr = 7'(a); tok_ep = 4'(e); tok_kind = 2'(k); eng_req = with_req;
        #1;
        if (with_req) chk("R11 eng_req ignored with token", int'(eng_ack), 0);
        @(posedge clk); #1;
        tok_valid = 0; eng_req = 0;
        if (check) begin
            chk("R3 hit", int'(tok_hit), int'(x >= 0));
            chk("R5 miss", int'(tok_miss), int'(x < 0));
            if (x >= 0) chk("R4 chosen slot", int'(tok_slot), x);
        end
        act = (x >= 0);
        if (act) begin
            aslot = x; aidx = 0;
            if (m_kind[x] != 1) m_cnt[x] = 0;
        end
        if (check && x < 0) begin
            @(negedge clk); eng_req = 1; #1;
            chk("R5 no engine access after miss", int'(eng_ack), 0);
            eng_req = 0;
        end
    endtask

    task automatic cfg_wr(input int slot, input int fld, input int val);
        if (act) token(0, 0, 0, 0, 0);
        @(negedge clk);
        cfg_sel = 1; cfg_write = 1; cfg_addr = {3'(slot), 3'(fld)}; cfg_wdata = 16'(val);
        @(posedge clk); #1;
        cfg_sel = 0; cfg_write = 0;
        if (slot < NS) begin
            case (fld)
                0: m_start[slot] = val % BUF;
                1: m_maxp[slot] = (val > BUF) ? BUF : val;
                2: m_kind[slot] = val & 3;
                3: m_ep[slot] = val & 15;
                default: ;
            endcase
        end else if (fld == 0) m_dev = val & 127;
    endtask

    task automatic cfg_rd(input int slot, input int fld, input int exp, input string req);
        @(negedge clk);
        cfg_sel = 1; cfg_write = 0; cfg_addr = {3'(slot), 3'(fld)};
        #1;
        chk(req, int'(cfg_rdata), exp);
        cfg_sel = 0;
    endtask

    task automatic cpu_write(input int a, input int d);
        @(negedge clk);
        cpu_req = 1; cpu_wr = 1; cpu_addr = 9'(a); cpu_wdata = 8'(d);
        #1;
        chk("R10 idle grant", int'(cpu_gnt), 1);
        @(posedge clk); #1;
        cpu_req = 0; cpu_wr = 0;
        m_mem[a] = 8'(d);
    endtask

    task automatic stream(input int n, input bit cpu_mix);
        for (int i = 0; i < n; i++) begin
            logic [7:0] wd = 8'($urandom);
            int ca = int'($urandom % BUF);
            bit cr = cpu_mix && ($urandom % 2 == 1);
            bit ea_ok = act && (aidx < m_maxp[aslot]);
            int ea = (m_start[aslot] + aidx) % BUF;
            @(negedge clk);
            eng_req = 1; eng_wdata = wd; cpu_req = cr; cpu_wr = 0; cpu_addr = 9'(ca);
            #1;
            chk("R7 ack vs cap", int'(eng_ack), int'(ea_ok));
            if (act) chk("R7 full flag", int'(eng_full), int'(!ea_ok));
            if (ea_ok) chk("R6 sram address", int'(eng_addr), ea);
            if (cr) chk("R10 cpu grant", int'(cpu_gnt), int'(!ea_ok));
            @(posedge clk); #1;
            eng_req = 0; cpu_req = 0;
            if (ea_ok) begin
                if (m_kind[aslot] == 1) chk("R9 in read data", int'(eng_rdata), int'(m_mem[ea]));
                else begin
                    m_mem[ea] = wd;
                    m_cnt[aslot] = aidx + 1;
                end
                aidx++;
            end
            if (cr && !ea_ok) chk("R10 cpu read data", int'(cpu_rdata), int'(m_mem[ca]));
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed = $urandom(32'h5EED_0042);
        seed = seed;
        for (int i = 0; i < NS; i++) begin
            m_start[i] = 0; m_maxp[i] = 0; m_kind[i] = 0; m_ep[i] = 0; m_cnt[i] = 0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset state
        #1;
        chk("R1 tok_hit low", int'(tok_hit), 0);
        chk("R1 tok_miss low", int'(tok_miss), 0);
        for (int s = 0; s < NS; s++)
            for (int f = 0; f < 5; f++) cfg_rd(s, f, 0, "R1 slot field zero");
        cfg_rd(6, 0, 0, "R1 device address zero");
        @(negedge clk); eng_req = 1; #1;
        chk("R1 no ack when idle", int'(eng_ack), 0);
        eng_req = 0;

        for (int a = 0; a < BUF; a++) cpu_write(a, int'($urandom % 256));

        // R2: configuration
        cfg_wr(6, 0, 42);
        cfg_wr(0, 0, 0);   cfg_wr(0, 1, 8);  cfg_wr(0, 2, 1); cfg_wr(0, 3, 1);
        cfg_wr(1, 0, 100); cfg_wr(1, 1, 16); cfg_wr(1, 2, 2); cfg_wr(1, 3, 2);
        cfg_wr(2, 0, 500); cfg_wr(2, 1, 20); cfg_wr(2, 2, 2); cfg_wr(2, 3, 3);
        cfg_wr(3, 0, 200); cfg_wr(3, 1, 4);  cfg_wr(3, 2, 3); cfg_wr(3, 3, 0);
        cfg_wr(4, 0, 300); cfg_wr(4, 1, 10); cfg_wr(4, 2, 2); cfg_wr(4, 3, 2);
        cfg_wr(5, 3, 5);   cfg_wr(5, 1, 1000);
        cfg_rd(6, 0, 42, "R2 device address");
        cfg_rd(2, 0, 500, "R2 start offset");
        cfg_rd(3, 2, 3, "R2 kind field");
        cfg_rd(4, 3, 2, "R2 endpoint field");
        cfg_rd(5, 1, 512, "R2 cap saturates at 512");
        cfg_wr(1, 4, 77);
        cfg_rd(1, 4, 0, "R2 count write ignored");

        // R9, R7: IN transfer beyond cap
        token(42, 1, 1, 0, 1);
        stream(10, 0);
        // R4, R8, R10: OUT with duplicate endpoint and CPU contention
        token(42, 2, 2, 0, 1);
        stream(20, 1);
        cfg_rd(1, 4, 16, "R8 count capped at payload");
        cfg_rd(4, 4, 0, "R4 higher slot untouched");
        // R6: wrap of window past 511
        token(42, 3, 2, 0, 1);
        stream(20, 1);
        cfg_rd(2, 4, 20, "R8 count after wrap");
        // R11, R8: SETUP with request during token
        token(42, 0, 3, 1, 1);
        stream(2, 0);
        cfg_rd(3, 4, 2, "R8 partial setup count");
        // R5, R3: misses
        token(41, 1, 1, 0, 1);
        token(42, 5, 2, 0, 1);
        token(42, 2, 1, 0, 1);
        // R7: zero cap
        cfg_wr(3, 1, 0);
        token(42, 0, 3, 0, 1);
        stream(3, 0);
        cfg_rd(3, 4, 0, "R7 zero cap accepts nothing");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom % 10);
            if (r == 0) begin
                int s = int'($urandom % NS);
                int f = int'($urandom % 4);
                int v = (f == 0) ? int'($urandom % BUF) : (f == 1) ? int'($urandom % 600)
                      : (f == 2) ? int'($urandom % 4) : int'($urandom % 6);
                cfg_wr(s, f, v);
            end else if (r == 1) begin
                int s = int'($urandom % NS);
                cfg_rd(s, 4, m_cnt[s], "R8 random count readback");
            end else begin
                int a = ($urandom % 4 == 0) ? int'($urandom % 128) : m_dev;
                token(a, int'($urandom % 6), int'($urandom % 4), bit'($urandom % 2), 1);
                if (act) stream(int'($urandom % 24), 1);
            end
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule